// File: doc/BRIEF.md
# Receive DMA Channel with Descriptor Ring

The block moves received frames from a byte-wide input FIFO into memory. Software lays out a ring of 8-byte descriptors in one 4 KiB page. Each descriptor gives a buffer size and a buffer address. Software then posts descriptors by moving a pointer register. The channel fetches a descriptor only when input data is waiting. It writes the frame bytes one per memory request. When a frame does not fit in one buffer, it continues into the next descriptor. The first buffer of every frame begins after a programmable number of offset bytes. The channel never writes descriptors back.

Software sees four word registers. A control word holds the enable bit, the frame offset and a bypass flag that keeps the engine out of the data path. A ring base register and a posted-pointer register follow. A read-only status word packs the ring position, the channel state and a coded error. Any error halts the channel until software clears the enable bit and sets it again. A one-cycle interrupt pulse marks every completed frame.

The memory port carries one request at a time. The request is a one-cycle strobe. The response comes on a later cycle and carries read data and an error flag. Write requests are answered in the same way.

Top module: `rxq_dma`

## Requirements
- R1: After reset, the status register (register index 3) reads 0, `in_ready_o` is low, no memory request is issued and `irq_o` is low.
- R2: The channel fetches a descriptor as two word reads. The first read is at {ring base[31:12], current offset}. Its bits [12:0] give the buffer size in bytes and its bit 28 marks the end of the table. The second read is at that address plus 4 and returns the buffer address. The ring base is register index 1.
- R3: The first buffer of a frame receives data starting at buffer address + frame offset. The frame offset is control bits [7:1], and the control word is register index 0. Later buffers of the same frame start at offset 0. Bytes are written to consecutive addresses.
- R4: When a buffer fills before the frame ends, the frame continues in the next descriptor. The current descriptor offset advances by 8 on each descriptor load and wraps to 0 after a descriptor marked end-of-table.
- R5: The status word packs four fields. Bits [11:0] hold the offset of the next descriptor to load, and bits [31:20] hold the offset of the descriptor loaded last. Bits [19:16] hold the error code, and bits [15:12] hold the state: 0 for disabled or halted, 1 for active and 2 for waiting. State code 3 never appears.
- R6: A descriptor whose offset equals the posted pointer (register index 2, bits [11:0]) is not fetched. While the channel waits at that offset, status reports state 2. It resumes once the pointer moves.
- R7: While control bit 8 is set, the channel accepts no input bytes and makes no memory write.
- R8: An input overflow pulse (`in_ovf_i`) that arrives while a byte waits and the next descriptor is not posted sets error code 2 and halts the channel. While halted, `in_ready_o` stays low and no memory request is issued.
- R9: An error response to a buffer write sets error code 3. An error response to either descriptor read sets error code 4. Both halt the channel.
- R10: A descriptor with size 0, or a first buffer whose size is not greater than the frame offset, sets error code 1 and halts the channel.
- R11: `irq_o` pulses high for exactly one cycle after the memory write of the last byte of a frame completes.
- R12: Control bit 0 enables the channel. Clearing the bit and then setting it again restarts the channel: the error clears and the descriptor offsets return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index: 0 control, 1 ring base, 2 posted pointer, 3 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Input byte ends a frame |
| in_ovf_i | input | 1 | Input FIFO overflow pulse |
| in_ready_o | output | 1 | Channel takes the input byte |
| mem_req_o | output | 1 | Memory request strobe, one cycle |
| mem_we_o | output | 1 | Request is a byte write |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rvalid_i | input | 1 | Response valid |
| mem_rdata_i | input | 32 | Read response data |
| mem_err_i | input | 1 | Response carries a bus error |
| irq_o | output | 1 | Frame-complete pulse |

## Verification
Each memory write is due in the cycle after the channel takes a byte, and each descriptor read is due two cycles after the one before it. The bench therefore does not time them. Its memory model captures every write strobe half a cycle after it rises and compares it against the next expected address and byte, which the input driver queued from the requirements. Responses return exactly one cycle after the strobe, so halts and interrupts land at fixed points. Status, interrupt counts and request counts are read only after the stimulus has had time to settle: idle gaps of several cycles follow each frame or error before any register read, and the reads happen on the falling edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ADDR_W  = 32;
  localparam int PTR_W   = 12;
  localparam int SIZE_W  = 13;
  localparam int OFS_W   = 7;
  localparam int BYTE_W  = 8;
  localparam int EOT_BIT = 28;
  localparam int DESC_B  = 8;

  typedef enum logic [3:0] {
    ST_OFF, ST_WAIT, ST_RD0, ST_RW0, ST_RD1, ST_RW1,
    ST_DATA, ST_WRQ, ST_WRW, ST_HALT
  } fsm_e;

  localparam logic [3:0] SC_DIS  = 4'd0;
  localparam logic [3:0] SC_ACT  = 4'd1;
  localparam logic [3:0] SC_IDLE = 4'd2;

  localparam logic [3:0] EC_NONE = 4'd0;
  localparam logic [3:0] EC_DPE  = 4'd1;
  localparam logic [3:0] EC_OVF  = 4'd2;
  localparam logic [3:0] EC_BWR  = 4'd3;
  localparam logic [3:0] EC_BDR  = 4'd4;
endpackage

// File: rtl/rxq_regs.sv
module rxq_regs #(
  parameter int AW = 32,
  parameter int PW = 12,
  parameter int OW = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [1:0]     addr_i,
  input  logic [31:0]    wdata_i,
  input  logic [31:0]    status_i,
  output logic [31:0]    rdata_o,
  output logic           en_o,
  output logic           pio_o,
  output logic [OW-1:0]  ofs_o,
  output logic [AW-PW-1:0] base_o,
  output logic [PW-1:0]  last_o
);
  localparam int CW = OW + 2;

  logic [CW-1:0]    ctrl_q;
  logic [AW-PW-1:0] base_q;
  logic [PW-1:0]    last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      base_q <= '0;
      last_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        2'd0: ctrl_q <= wdata_i[CW-1:0];
        2'd1: base_q <= wdata_i[AW-1:PW];
        2'd2: last_q <= wdata_i[PW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      2'd0: rdata_o = 32'(ctrl_q);
      2'd1: rdata_o = {base_q, {PW{1'b0}}};
      2'd2: rdata_o = 32'(last_q);
      default: rdata_o = status_i;
    endcase
  end

  assign en_o   = ctrl_q[0];
  assign ofs_o  = ctrl_q[OW:1];
  assign pio_o  = ctrl_q[OW+1];
  assign base_o = base_q;
  assign last_o = last_q;
endmodule

// File: rtl/rxq_engine.sv
module rxq_engine
  import rxq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PTR_W,
  parameter int SW = SIZE_W,
  parameter int OW = OFS_W,
  parameter int BW = BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pio_i,
  input  logic [OW-1:0]    ofs_i,
  input  logic [AW-PW-1:0] base_i,
  input  logic [PW-1:0]    last_i,
  input  logic             in_valid_i,
  input  logic [BW-1:0]    in_data_i,
  input  logic             in_last_i,
  input  logic             in_ovf_i,
  output logic             in_ready_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [BW-1:0]    mem_wdata_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_err_i,
  output logic             irq_o,
  output logic [PW-1:0]    cd_o,
  output logic [PW-1:0]    ad_o,
  output logic [3:0]       state_o,
  output logic [3:0]       err_o
);
  fsm_e            st_q;
  logic [PW-1:0]   cd_q, ad_q;
  logic [3:0]      err_q;
  logic [SW-1:0]   size_q, woff_q;
  logic            eot_q, first_q, last_q, irq_q;
  logic [AW-1:0]   baddr_q;
  logic [BW-1:0]   byte_q;

  logic stalled, bad_desc, buf_full;
  logic [SW-1:0] woff_nx;

  assign stalled  = (cd_q == last_i);
  assign woff_nx  = woff_q + SW'(1);
  assign buf_full = (woff_nx == size_q);
  assign bad_desc = (size_q == '0) || (first_q && (SW'(ofs_i) >= size_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OFF;
      cd_q    <= '0;
      ad_q    <= '0;
      err_q   <= EC_NONE;
      size_q  <= '0;
      woff_q  <= '0;
      eot_q   <= 1'b0;
      first_q <= 1'b1;
      last_q  <= 1'b0;
      irq_q   <= 1'b0;
      baddr_q <= '0;
      byte_q  <= '0;
    end else begin
      irq_q <= 1'b0;
      unique case (st_q)
        ST_OFF: if (en_i) begin
          cd_q    <= '0;
          ad_q    <= '0;
          err_q   <= EC_NONE;
          first_q <= 1'b1;
          st_q    <= ST_WAIT;
        end
        ST_HALT: if (!en_i) st_q <= ST_OFF;
        ST_WAIT: begin
          if (!en_i) st_q <= ST_OFF;
          else if (!pio_i && in_valid_i) begin
            if (!stalled) st_q <= ST_RD0;
            else if (in_ovf_i) begin
              err_q <= EC_OVF;
              st_q  <= ST_HALT;
            end
          end
        end
        ST_RD0: st_q <= ST_RW0;
        ST_RW0: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            err_q <= EC_BDR;
            st_q  <= ST_HALT;
          end else begin
            size_q <= mem_rdata_i[SW-1:0];
            eot_q  <= mem_rdata_i[EOT_BIT];
            st_q   <= ST_RD1;
          end
        end
        ST_RD1: st_q <= ST_RW1;
        ST_RW1: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            err_q <= EC_BDR;
            st_q  <= ST_HALT;
          end else if (bad_desc) begin
            err_q <= EC_DPE;
            st_q  <= ST_HALT;
          end else begin
            baddr_q <= mem_rdata_i[AW-1:0];
            woff_q  <= first_q ? SW'(ofs_i) : '0;
            ad_q    <= cd_q;
            cd_q    <= eot_q ? '0 : cd_q + PW'(DESC_B);
            st_q    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (!en_i) st_q <= ST_OFF;
          else if (in_valid_i && !pio_i) begin
            byte_q <= in_data_i;
            last_q <= in_last_i;
            st_q   <= ST_WRQ;
          end
        end
        ST_WRQ: st_q <= ST_WRW;
        ST_WRW: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            err_q <= EC_BWR;
            st_q  <= ST_HALT;
          end else begin
            woff_q  <= woff_nx;
            first_q <= last_q;
            irq_q   <= last_q;
            st_q    <= (last_q || buf_full) ? ST_WAIT : ST_DATA;
          end
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_OFF, ST_HALT: state_o = SC_DIS;
      ST_WAIT:         state_o = SC_IDLE;
      default:         state_o = SC_ACT;
    endcase
  end

  assign in_ready_o  = (st_q == ST_DATA) && !pio_i;
  assign mem_req_o   = (st_q == ST_RD0) || (st_q == ST_RD1) || (st_q == ST_WRQ);
  assign mem_we_o    = (st_q == ST_WRQ);
  assign mem_wdata_o = byte_q;
  assign mem_addr_o  = (st_q == ST_WRQ) ? baddr_q + AW'(woff_q)
                     : (st_q == ST_RD1) ? {base_i, cd_q[PW-1:3], 3'b100}
                     : {base_i, cd_q};
  assign irq_o = irq_q;
  assign cd_o  = cd_q;
  assign ad_o  = ad_q;
  assign err_o = err_q;

  a_r2_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r11_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r5_state_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= SC_IDLE);
  a_r3_in_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (woff_q < size_q));
  a_r6_no_fetch_at_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && stalled) |=> !mem_req_o);
  a_r7_pio_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pio_i && $past(pio_i)) |-> !(mem_req_o && mem_we_o));
  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != EC_NONE) |-> (!mem_req_o && !in_ready_o));
endmodule

// File: rtl/rxq_dma.sv
module rxq_dma
  import rxq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  input  logic        in_ovf_i,
  output logic        in_ready_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_err_i,
  output logic        irq_o
);
  logic                  en, pio;
  logic [OFS_W-1:0]      ofs;
  logic [ADDR_W-PTR_W-1:0] base;
  logic [PTR_W-1:0]      last_ptr, cd, ad;
  logic [3:0]            state, err;
  logic [31:0]           status;

  assign status = {ad, err, state, cd};

  rxq_regs #(.AW(ADDR_W), .PW(PTR_W), .OW(OFS_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .status_i(status), .rdata_o(reg_rdata_o),
    .en_o(en), .pio_o(pio), .ofs_o(ofs), .base_o(base), .last_o(last_ptr)
  );

  rxq_engine #(.AW(ADDR_W), .PW(PTR_W), .SW(SIZE_W), .OW(OFS_W), .BW(BYTE_W)) u_eng (
    .clk_i, .rst_ni,
    .en_i(en), .pio_i(pio), .ofs_i(ofs), .base_i(base), .last_i(last_ptr),
    .in_valid_i, .in_data_i, .in_last_i, .in_ovf_i, .in_ready_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rvalid_i, .mem_rdata_i, .mem_err_i,
    .irq_o, .cd_o(cd), .ad_o(ad), .state_o(state), .err_o(err)
  );
endmodule

// File: tb/rxq_dma_test.sv
`timescale 1ns/1ps
module rxq_dma_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd3;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_valid = 1'b0, in_last = 1'b0, in_ovf = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic mem_req, mem_we, mem_rvalid = 1'b0, mem_err = 1'b0, irq;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [7:0] mem_wdata;

  int n_chk = 0, n_bad = 0, n_req = 0, n_irq = 0;
  logic [7:0] mem [0:8191];
  logic [39:0] sb_q[$];
  logic pend = 1'b0, pend_err = 1'b0;
  logic [31:0] pend_data = '0;
  logic wr_err = 1'b0, rd_err = 1'b0;

  always #2 clk = ~clk;

  rxq_dma uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last), .in_ovf_i(in_ovf),
    .in_ready_o(in_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor, one response cycle after each strobe
  always @(negedge clk) begin
    logic [12:0] a;
    mem_rvalid = pend;
    mem_err    = pend_err;
    mem_rdata  = pend_data;
    pend = 1'b0;
    if (irq) n_irq++;
    if (mem_req) begin
      n_req++;
      pend = 1'b1;
      a = mem_addr[12:0];
      if (mem_we) begin
        pend_err = wr_err;
        if (!wr_err) mem[a] = mem_wdata;
        n_chk++;
        if (sb_q.size() == 0) begin
          n_bad++;
          $display("FAIL R3/R4 write: actual %h@%h expected none", mem_wdata, mem_addr);
        end else begin
          logic [39:0] e;
          e = sb_q.pop_front();
          if ({mem_addr, mem_wdata} !== e) begin
            n_bad++;
            $display("FAIL R3/R4 write: actual %h@%h expected %h@%h",
                     mem_wdata, mem_addr, e[7:0], e[39:8]);
          end
        end
      end else begin
        pend_err  = rd_err;
        pend_data = {mem[a+13'd3], mem[a+13'd2], mem[a+13'd1], mem[a]};
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0; reg_addr = 2'd3;
  endtask

  function automatic logic [31:0] status();
    return reg_rdata;
  endfunction

  task automatic set_desc(int idx, logic [12:0] size, logic eot, logic [31:0] addr);
    logic [31:0] w;
    int b;
    w = {3'b000, eot, 15'd0, size};
    b = 32'h1000 + idx * 8;
    for (int i = 0; i < 4; i++) begin
      mem[b + i]     = w[8*i +: 8];
      mem[b + 4 + i] = addr[8*i +: 8];
    end
  endtask

  // driver: queues the expected write, then hands the byte over
  task automatic xfer(logic [31:0] addr, int n, logic [7:0] d0, logic fin);
    for (int i = 0; i < n; i++) begin
      sb_q.push_back({addr + 32'(i), d0 + 8'(i)});
      in_valid = 1'b1; in_data = d0 + 8'(i); in_last = fin && (i == n - 1);
      while (!in_ready) step(1);
      step(1);
      in_valid = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic restart(logic [31:0] ctrl);
    wreg(2'd0, 32'd0);
    step(2);
    wreg(2'd0, ctrl);
    step(2);
  endtask

  task automatic abandon();
    disable fork;
    in_valid = 1'b0; in_last = 1'b0;
    sb_q.delete();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int reqs, irqs;
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    set_desc(0, 13'd16, 1'b0, 32'h100);
    set_desc(1, 13'd8,  1'b0, 32'h200);
    set_desc(2, 13'd32, 1'b1, 32'h300);
    step(3);
    chk("R1 status after reset", status(), 32'h0);
    chk("R1 ready after reset", 32'(in_ready), 32'h0);
    chk("R1 req after reset", 32'(mem_req), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    step(2);
    wreg(2'd1, 32'h1000);
    wreg(2'd2, 32'h10);
    wreg(2'd0, 32'h9);  // enable, offset 4
    step(2);

    // frame of 20 bytes: 12 after the offset in desc0, then 8 filling desc1
    xfer(32'h104, 12, 8'h10, 1'b0);
    xfer(32'h200, 8, 8'h1c, 1'b1);
    step(6);
    chk("R4 R5 status after chained frame", status(), 32'h0080_2010);
    chk("R11 irq after first frame", 32'(n_irq), 32'd1);
    chk("R2 R3 buffer byte in memory", 32'(mem[13'h104]), 32'h10);

    // R6: pointer at 0x10 blocks desc2
    reqs = n_req;
    fork xfer(32'h304, 3, 8'h40, 1'b1); join_none
    step(12);
    chk("R6 stalled state", status(), 32'h0080_2010);
    chk("R6 no fetch at pointer", 32'(n_req - reqs), 32'd0);
    wreg(2'd2, 32'h08);
    wait (sb_q.size() == 0);
    step(8);
    chk("R4 wrap after end-of-table", status(), 32'h0100_2000);
    chk("R11 irq count", 32'(n_irq), 32'd2);

    // R7: bypass flag holds the engine out of the data path
    wreg(2'd0, 32'h109);
    reqs = n_req;
    fork xfer(32'h104, 1, 8'h55, 1'b1); join_none
    step(15);
    chk("R7 no memory traffic in bypass", 32'(n_req - reqs), 32'd0);
    chk("R7 byte not taken in bypass", 32'(sb_q.size()), 32'd1);
    wreg(2'd0, 32'h9);
    wait (sb_q.size() == 0);
    step(8);
    chk("R7 resume after bypass", status(), 32'h0000_2008);

    // R8: overflow while stalled at pointer 0x08
    fork xfer(32'h114, 1, 8'h66, 1'b1); join_none
    step(5);
    in_ovf = 1'b1; step(1); in_ovf = 1'b0;
    step(2);
    chk("R8 overflow error", status(), 32'h0002_0008);
    reqs = n_req;
    step(6);
    chk("R8 halted no requests", 32'(n_req - reqs), 32'd0);
    chk("R8 halted not ready", 32'(in_ready), 32'd0);
    abandon();
    restart(32'h9);
    chk("R12 restart clears error", status(), 32'h0000_2000);

    // R9: write error
    wreg(2'd2, 32'h10);
    wr_err = 1'b1;
    xfer(32'h104, 1, 8'h77, 1'b0);
    step(6);
    wr_err = 1'b0;
    chk("R9 buffer write error", status(), 32'h0003_0008);
    restart(32'h9);

    // R9: descriptor read error
    rd_err = 1'b1;
    fork xfer(32'h104, 1, 8'h78, 1'b1); join_none
    step(10);
    rd_err = 1'b0;
    chk("R9 descriptor read error", status(), 32'h0004_0000);
    abandon();
    restart(32'h9);

    // R10: zero size
    set_desc(0, 13'd0, 1'b0, 32'h100);
    fork xfer(32'h104, 1, 8'h79, 1'b1); join_none
    step(10);
    chk("R10 zero-size descriptor", status(), 32'h0001_0000);
    abandon();
    // R10: offset not below size
    set_desc(0, 13'd4, 1'b0, 32'h100);
    restart(32'h9);
    fork xfer(32'h104, 1, 8'h7a, 1'b1); join_none
    step(10);
    chk("R10 offset beyond buffer", status(), 32'h0001_0000);
    abandon();

    // offset 0, frame of 3 in desc0
    set_desc(0, 13'd16, 1'b0, 32'h100);
    restart(32'h1);
    irqs = n_irq;
    xfer(32'h100, 3, 8'h90, 1'b1);
    step(6);
    chk("R3 zero offset frame end", 32'(mem[13'h102]), 32'h92);
    chk("R11 one pulse per frame", 32'(n_irq - irqs), 32'd1);
    chk("R12 offsets after restart", status(), 32'h0000_2008);
    chk("R3 scoreboard drained", 32'(sb_q.size()), 32'd0);
    summary();
  end
endmodule